// File: doc/BRIEF.md
# Operand Stack Store with Write Forwarding

This block is the operand stack for a pipelined stack-machine core. It has its own storage, apart from the program and data memory, so a runaway stack cannot corrupt code. Each cycle the core may push a value, pop the top, or do both at once. The current top of stack is always visible on an output. A down-counting stack pointer tracks the occupancy.

Writes to the array are delayed by one cycle. A push first lands in a holding write register, and the array write commits at the next clock edge. While the write register holds data that is not yet committed, the top-of-stack output is served from it. A pop that follows a push at once therefore sees the pushed value without touching the array.

The parameter `MEM_SYNC` picks the storage style:
- `MEM_SYNC=1` gives a pseudo dual-port memory with one write port and one registered read port. A read that coincides with a commit to the same slot is corrected by a bypass register.
- `MEM_SYNC=0` gives plain register or distributed storage with an asynchronous read.

Top module: `stack_bypass_mem`

## Requirements
- R1: After reset, `empty_o` is 1, `full_o` is 0, `depth_o` is 0 and `tos_o` is 0.
- R2: A push alone on a stack that is not full raises `depth_o` by one. In the next cycle, `tos_o` equals the pushed word.
- R3: A pop alone on a stack that is not empty lowers `depth_o` by one. In the next cycle, `tos_o` shows the element that was below the removed top (last in, first out).
- R4: A push and a pop in the same cycle on a stack that is not empty replace the top with the pushed word and leave `depth_o` unchanged. This holds even when the stack is full.
- R5: A push without a pop while `full_o` is 1 is ignored. `depth_o` and `tos_o` keep their values.
- R6: A pop while `empty_o` is 1 is ignored. If a push comes in the same cycle, it behaves as a plain push.
- R7: A pop in the cycle right after a push returns the stack to the state it had before that push. The element below the removed top shows on `tos_o`.
- R8: A value whose array write commits in a given cycle is read back correctly in the next cycle from the same slot. For example: push, one idle cycle, then read the top or pop down to it.
- R9: `tos_o` is 0 whenever the stack is empty. `full_o` is 1 exactly when `depth_o` equals `DEPTH`.
- R10: Both storage styles (`MEM_SYNC` 0 and 1) give identical port behaviour for the same stimulus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| push_i | input | 1 | Push request |
| pop_i | input | 1 | Pop request |
| push_data_i | input | DW | Word to push |
| tos_o | output | DW | Current top of stack, 0 when empty |
| depth_o | output | $clog2(DEPTH)+1 | Number of stored elements |
| empty_o | output | 1 | Stack holds no element |
| full_o | output | 1 | Stack holds DEPTH elements |

## Verification
Random mixes of push, pop, replace and idle run against a queue model. The mixes are biased in turn toward filling and toward draining, so that both the full edge and the empty edge are reached many times. Back-to-back push then pop separates the write-register path from the array path. Push followed by an idle cycle separates the committed-slot bypass from a stale array read. Pushes at full and pops at empty show that ignored requests change nothing. A registered-storage copy driven alongside the memory copy shows that the two storage styles cannot be told apart at the ports.

// File: rtl/stack_bypass_mem.sv
module stack_bypass_mem #(
  parameter int DW       = 16,
  parameter int DEPTH    = 16,
  parameter bit MEM_SYNC = 1'b1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         push_i,
  input  logic                         pop_i,
  input  logic [DW-1:0]                push_data_i,
  output logic [DW-1:0]                tos_o,
  output logic [$clog2(DEPTH):0]       depth_o,
  output logic                         empty_o,
  output logic                         full_o
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;
  localparam logic [PW-1:0] SP_TOP = PW'(DEPTH);

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] sp, sp_nx;
  logic          pop_ok, push_ok;
  logic          wreg_vld;
  logic [AW-1:0] wreg_addr;
  logic [DW-1:0] wreg_data;
  logic [DW-1:0] arr_rd;

  assign empty_o = (sp == SP_TOP);
  assign full_o  = (sp == '0);
  assign depth_o = SP_TOP - sp;

  assign pop_ok  = pop_i & ~empty_o;
  assign push_ok = push_i & (~full_o | pop_ok);

  always_comb begin
    sp_nx = sp;
    if (push_ok && !pop_ok)      sp_nx = sp - 1'b1;
    else if (pop_ok && !push_ok) sp_nx = sp + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp        <= SP_TOP;
      wreg_vld  <= 1'b0;
      wreg_addr <= '0;
      wreg_data <= '0;
    end else begin
      sp       <= sp_nx;
      wreg_vld <= push_ok;
      if (push_ok) begin
        wreg_addr <= sp_nx[AW-1:0];
        wreg_data <= push_data_i;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (wreg_vld) mem[wreg_addr] <= wreg_data;
  end

  generate
    if (MEM_SYNC) begin : g_pdp
      logic [DW-1:0] rd_q, byp_data;
      logic          byp_hit;
      always_ff @(posedge clk) begin
        rd_q <= mem[sp_nx[AW-1:0]];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          byp_hit  <= 1'b0;
          byp_data <= '0;
        end else begin
          byp_hit  <= wreg_vld && (wreg_addr == sp_nx[AW-1:0]);
          byp_data <= wreg_data;
        end
      end
      assign arr_rd = byp_hit ? byp_data : rd_q;
    end else begin : g_regs
      assign arr_rd = mem[sp[AW-1:0]];
    end
  endgenerate

  assign tos_o = empty_o  ? '0 :
                 wreg_vld ? wreg_data : arr_rd;
endmodule

// File: rtl/stack_bypass_mem_chk.sv
module stack_bypass_mem_chk #(
  parameter int DW    = 16,
  parameter int DEPTH = 16
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   push_i,
  input logic                   pop_i,
  input logic [DW-1:0]          push_data_i,
  input logic [DW-1:0]          tos_o,
  input logic [$clog2(DEPTH):0] depth_o,
  input logic                   empty_o,
  input logic                   full_o
);
  localparam int PW = $clog2(DEPTH) + 1;

  assert_push_top_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && !pop_i && !full_o) |=> (tos_o == $past(push_data_i) && depth_o == $past(depth_o) + 1'b1));

  assert_pop_depth_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && !push_i && !empty_o) |=> (depth_o == $past(depth_o) - 1'b1));

  assert_replace_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && push_i && !empty_o) |=> (tos_o == $past(push_data_i) && $stable(depth_o)));

  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && !pop_i && full_o) |=> ($stable(depth_o) && $stable(tos_o)));

  assert_no_underflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && !push_i && empty_o) |=> empty_o);

  assert_empty_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    empty_o |-> (tos_o == '0 && depth_o == '0));

  assert_depth_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (depth_o <= PW'(DEPTH)) && (full_o == (depth_o == PW'(DEPTH))));
endmodule

bind stack_bypass_mem stack_bypass_mem_chk #(.DW(DW), .DEPTH(DEPTH)) u_chk (.*);

// File: tb/tb_stack_bypass_mem.sv
module tb_stack_bypass_mem;
  localparam int DW = 16;
  localparam int DEPTH = 16;
  localparam int PW = $clog2(DEPTH) + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic push_i = 1'b0, pop_i = 1'b0;
  logic [DW-1:0] push_data_i = '0;
  logic [DW-1:0] tos_a, tos_b;
  logic [PW-1:0] dep_a, dep_b;
  logic emp_a, emp_b, ful_a, ful_b;

  int checks = 0;
  int errors = 0;
  logic [DW-1:0] model [$];

  always #10 clk = ~clk;

  stack_bypass_mem #(.DW(DW), .DEPTH(DEPTH), .MEM_SYNC(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .push_i(push_i), .pop_i(pop_i), .push_data_i(push_data_i),
    .tos_o(tos_a), .depth_o(dep_a), .empty_o(emp_a), .full_o(ful_a));

  stack_bypass_mem #(.DW(DW), .DEPTH(DEPTH), .MEM_SYNC(1'b0)) dut_reg (
    .clk(clk), .rst_n(rst_n), .push_i(push_i), .pop_i(pop_i), .push_data_i(push_data_i),
    .tos_o(tos_b), .depth_o(dep_b), .empty_o(emp_b), .full_o(ful_b));

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] exp_tos();
    return (model.size() == 0) ? '0 : model[model.size()-1];
  endfunction

  task automatic compare(input string req);
    chk(tos_a == exp_tos(), req, tos_a, exp_tos());
    chk(dep_a == PW'(model.size()), req, dep_a, model.size());
    chk(emp_a == (model.size() == 0) && ful_a == (model.size() == DEPTH), {req, "_R9"},
        {emp_a, ful_a}, {model.size() == 0, model.size() == DEPTH});
    chk({tos_b, dep_b, emp_b, ful_b} == {tos_a, dep_a, emp_a, ful_a}, "R10",
        {tos_b, dep_b}, {tos_a, dep_a});
  endtask

  task automatic step(input bit pu, input bit po, input logic [DW-1:0] d, input string req);
    push_i = pu; pop_i = po; push_data_i = d;
    if (po && model.size() != 0) begin
      void'(model.pop_back());
      if (pu) model.push_back(d);
    end else if (pu && model.size() < DEPTH) begin
      model.push_back(d);
    end
    @(negedge clk);
    compare(req);
  endtask

  initial begin
    #20_000_000;
    errors++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5A17));
    repeat (2) @(negedge clk);
    compare("R1");
    rst_n = 1'b1;
    @(negedge clk);
    compare("R1");

    step(1, 1, 16'h1111, "R6");
    step(0, 1, 16'h0, "R6");
    step(0, 1, 16'h0, "R6");
    step(1, 0, 16'hA0A0, "R2");
    step(1, 0, 16'hB1B1, "R2");
    step(0, 1, 16'h0, "R7");
    step(0, 0, 16'h0, "R8");
    step(1, 0, 16'hC2C2, "R2");
    step(0, 0, 16'h0, "R8");
    step(0, 1, 16'h0, "R8");
    step(1, 1, 16'hD3D3, "R4");
    step(0, 0, 16'h0, "R8");
    step(0, 1, 16'h0, "R3");
    step(0, 1, 16'h0, "R3");

    for (int i = 0; i < DEPTH; i++) step(1, 0, DW'(16'hE000 + i), "R2");
    step(1, 0, 16'hFFFF, "R5");
    step(1, 0, 16'hFFFE, "R5");
    step(1, 1, 16'h7777, "R4");
    step(0, 1, 16'h0, "R7");
    for (int i = 0; i < DEPTH + 2; i++) step(0, 1, 16'h0, "R3");

    for (int i = 0; i < 4000; i++) begin
      int r = int'($urandom_range(0, 99));
      bit fill = ((i / 300) % 2) == 0;
      int ppush = fill ? 60 : 30;
      bit pu, po;
      pu = r < ppush;
      po = (r >= ppush - 10) && (r < ppush + 35);
      step(pu, po, DW'($urandom()), pu && po ? "R4" : pu ? "R2" : po ? "R3" : "R8");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule